// File: doc/BRIEF.md
# Handshaking Byte Port with Four Transfer Modes

This block links a CPU register interface to an external device over an 8-bit data bus. It signals the device through active-low strobe inputs and active-high ready outputs. A two-bit mode value picks one of four behaviours. In output mode the CPU writes a byte and the device acknowledges it. In input mode the device deposits a byte and the CPU collects it. Bidirectional mode runs both directions over one bus and uses a second strobe/ready pair for the inbound side. Bit-control mode drives and reads individual bits with no handshake.

Both strobes pass through a synchronizer in the system clock domain, and the handshake logic acts on their synchronized rising edges. When an outbound acknowledge or an inbound capture completes, the block raises a one-cycle interrupt-request pulse. The bus is split into separate input pins, output data and a per-bit output enable, so the pad ring can build the tristate.

Top module: `pport_ctrl`

## Requirements
- R1: After the synchronous active-low reset, the mode is input (code 01), nothing drives the bus (`pin_oe` = 0), `rdy_a` = 1, `rdy_b` = 0 and `irq` = 0.
- R2: In output mode (code 00), a CPU write with `cpu_sel` = 0 loads the byte onto `pin_out`. `pin_oe` is all ones in this mode, and `rdy_a` is high from the cycle after the write.
- R3: In output mode, a synchronized rising edge on `stb_a_n` drops `rdy_a`, and `rdy_a` stays low until the next data write. The acknowledge gives a one-cycle `irq` pulse.
- R4: In input mode (code 01), `rdy_a` is high while the input register is empty. The register samples `pin_in` while the synchronized `stb_a_n` is low. On the strobe's rising edge the register becomes full, `rdy_a` drops and `irq` pulses once.
- R5: In input or bidirectional mode, a CPU read with `cpu_sel` = 0 returns the input register on `cpu_rdata` and marks it empty, so the matching ready rises again.
- R6: Once the input register is full, further strobes change neither its contents nor `irq` until the CPU reads it.
- R7: In bidirectional mode (code 10), `pin_oe` is all ones only while the synchronized `stb_a_n` is low, and 0 otherwise. `rdy_a` is high while a written byte has not been acknowledged. The rising edge of `stb_a_n` acknowledges the byte and pulses `irq`.
- R8: In bidirectional mode, `stb_b_n` loads `pin_in` into the input register, `rdy_b` is high while that register is empty, and the capture pulses `irq`. Outside bidirectional mode `rdy_b` is 0.
- R9: In bit-control mode (code 11), both strobes are ignored and both readies are 0. `pin_oe` equals the direction mask written with `cpu_sel` = 2 (1 = drive). A read with `cpu_sel` = 0 returns `pin_in` directly.
- R10: A read with `cpu_sel` = 1 returns the current mode code in bits 1:0, with the upper bits zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cpu_wr | input | 1 | CPU write strobe, one cycle |
| cpu_rd | input | 1 | CPU read strobe, one cycle |
| cpu_sel | input | 2 | Register select: 0 data, 1 mode, 2 direction mask |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | CPU read data (combinational) |
| pin_in | input | 8 | Bus value seen at the pins |
| pin_out | output | 8 | Bus value to drive |
| pin_oe | output | 8 | Per-bit drive enable |
| stb_a_n | input | 1 | Primary strobe, active low |
| stb_b_n | input | 1 | Secondary strobe, active low |
| rdy_a | output | 1 | Primary ready |
| rdy_b | output | 1 | Secondary ready |
| irq | output | 1 | Interrupt-request pulse, one cycle |

## Verification
The bench builds the block with its defaults: an 8-bit bus and a two-stage strobe synchronizer. With two stages, the oe window and the ready drop can be sampled a few cycles after each strobe change. The 8-bit width lets a four-bit direction mask show driven and undriven halves at the same time. Every handshake that should finish queues an expected interrupt. The bench then checks that each `irq` pulse matches a queued entry, and that ignored strobes leave the queue untouched.

// File: rtl/pport_pkg.sv
// Shared mode codes and register selects for the handshaking byte port.
package pport_pkg;
    typedef enum logic [1:0] {
        MODE_OUT   = 2'b00,
        MODE_IN    = 2'b01,
        MODE_BIDIR = 2'b10,
        MODE_CTRL  = 2'b11
    } pmode_t;

    localparam logic [1:0] SEL_DATA = 2'd0;
    localparam logic [1:0] SEL_MODE = 2'd1;
    localparam logic [1:0] SEL_MASK = 2'd2;
endpackage

// File: rtl/pport_strobe_sync.sv
// Brings an asynchronous active-low strobe into the clock domain.
// Outputs the synchronized asserted level and a one-cycle rising-edge event.
// Assumes STAGES >= 2; the reset state is "strobe idle" (high).
module pport_strobe_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stb_n,
    output logic active,
    output logic rise_evt
);
    logic [STAGES:0] chain;

    // Shift chain: STAGES synchronizer flops plus one history flop for edge detect.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-1:0], stb_n};
    end

    assign active   = !chain[STAGES-1];
    assign rise_evt = chain[STAGES-1] && !chain[STAGES];

    // R3: a rising edge must follow a cycle in which the strobe was seen asserted.
    a_r3_rise_after_low: assert property (@(posedge clk) disable iff (!rst_n)
        rise_evt |-> $past(active));
endmodule

// File: rtl/pport_out_chan.sv
// Outbound holding register with its "not yet taken" flag.
// A CPU load sets the flag; an acknowledge clears it. A load wins a same-cycle tie.
module pport_out_chan #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] load_data,
    input  logic             ack,
    output logic [WIDTH-1:0] data,
    output logic             full,
    output logic             done_evt
);
    // Holding register for the byte to send.
    always_ff @(posedge clk) begin
        if (!rst_n)    data <= '0;
        else if (load) data <= load_data;
    end

    // Pending flag: set on a write, cleared by the peripheral's acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)    full <= 1'b0;
        else if (load) full <= 1'b1;
        else if (ack)  full <= 1'b0;
    end

    assign done_evt = ack && full && !load;

    a_r2_load_sets_full: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> full);
    a_r3_ack_clears_full: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && full && !load) |=> !full);
endmodule

// File: rtl/pport_in_chan.sv
// Inbound capture register. While empty and enabled it samples the pins as long
// as the strobe is asserted; the strobe's rising edge marks it full. A CPU take
// empties it. Assumes peripheral data is stable while its strobe is low.
module pport_in_chan #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             stb_active,
    input  logic             stb_rise,
    input  logic             take,
    input  logic [WIDTH-1:0] pins,
    output logic [WIDTH-1:0] data,
    output logic             full,
    output logic             cap_evt
);
    assign cap_evt = enable && !full && stb_rise;

    // Sample the bus while the strobe is held and the register is free.
    always_ff @(posedge clk) begin
        if (!rst_n)                             data <= '0;
        else if (enable && !full && stb_active) data <= pins;
    end

    // Full flag: set at capture completion, cleared by the CPU read.
    always_ff @(posedge clk) begin
        if (!rst_n)       full <= 1'b0;
        else if (cap_evt) full <= 1'b1;
        else if (take)    full <= 1'b0;
    end

    a_r6_hold_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        full |=> $stable(data));
    a_r4_rise_fills: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !full && stb_rise) |=> full);
endmodule

// File: rtl/pport_ctrl.sv
// Top of the handshaking byte port. It holds the mode and direction mask,
// routes the two synchronized strobes to the outbound and inbound channels
// by mode, and forms ready, drive enable, read data and the interrupt pulse.
// Assumes single-cycle cpu_wr/cpu_rd strobes, never both in one cycle.
module pport_ctrl
    import pport_pkg::*;
#(
    parameter int WIDTH       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cpu_wr,
    input  logic             cpu_rd,
    input  logic [1:0]       cpu_sel,
    input  logic [WIDTH-1:0] cpu_wdata,
    output logic [WIDTH-1:0] cpu_rdata,
    input  logic [WIDTH-1:0] pin_in,
    output logic [WIDTH-1:0] pin_out,
    output logic [WIDTH-1:0] pin_oe,
    input  logic             stb_a_n,
    input  logic             stb_b_n,
    output logic             rdy_a,
    output logic             rdy_b,
    output logic             irq
);
    localparam int PAD = WIDTH - 2;

    pmode_t           mode;
    logic [WIDTH-1:0] dir_mask;
    logic             a_act, a_rise, b_act, b_rise;
    logic             out_full, out_done;
    logic [WIDTH-1:0] in_data;
    logic             in_full, in_cap;
    logic             is_bidir, in_enable;

    assign is_bidir  = (mode == MODE_BIDIR);
    assign in_enable = (mode == MODE_IN) || is_bidir;

    // Configuration registers: mode and bit-control direction mask.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode     <= MODE_IN;
            dir_mask <= '0;
        end else if (cpu_wr && cpu_sel == SEL_MODE) begin
            mode <= pmode_t'(cpu_wdata[1:0]);
        end else if (cpu_wr && cpu_sel == SEL_MASK) begin
            dir_mask <= cpu_wdata;
        end
    end

    pport_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync_a (
        .clk(clk), .rst_n(rst_n), .stb_n(stb_a_n), .active(a_act), .rise_evt(a_rise));
    pport_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync_b (
        .clk(clk), .rst_n(rst_n), .stb_n(stb_b_n), .active(b_act), .rise_evt(b_rise));

    pport_out_chan #(.WIDTH(WIDTH)) u_out (
        .clk(clk), .rst_n(rst_n),
        .load(cpu_wr && cpu_sel == SEL_DATA),
        .load_data(cpu_wdata),
        .ack(a_rise && (mode == MODE_OUT || is_bidir)),
        .data(pin_out), .full(out_full), .done_evt(out_done));

    pport_in_chan #(.WIDTH(WIDTH)) u_in (
        .clk(clk), .rst_n(rst_n),
        .enable(in_enable),
        .stb_active(is_bidir ? b_act : a_act),
        .stb_rise(is_bidir ? b_rise : a_rise),
        .take(cpu_rd && cpu_sel == SEL_DATA && in_enable),
        .pins(pin_in),
        .data(in_data), .full(in_full), .cap_evt(in_cap));

    // Interrupt request: one pulse per completed handshake in either direction.
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= out_done || in_cap;
    end

    // Ready and drive-enable selection by mode.
    always_comb begin
        rdy_b = is_bidir && !in_full;
        unique case (mode)
            MODE_OUT: begin
                rdy_a  = out_full;
                pin_oe = '1;
            end
            MODE_IN: begin
                rdy_a  = !in_full;
                pin_oe = '0;
            end
            MODE_BIDIR: begin
                rdy_a  = out_full;
                pin_oe = a_act ? '1 : '0;
            end
            default: begin
                rdy_a  = 1'b0;
                pin_oe = dir_mask;
            end
        endcase
    end

    // CPU read data multiplexer.
    always_comb begin
        unique case (cpu_sel)
            SEL_DATA: cpu_rdata = (mode == MODE_CTRL) ? pin_in : in_data;
            SEL_MODE: cpu_rdata = {{PAD{1'b0}}, mode};
            SEL_MASK: cpu_rdata = dir_mask;
            default:  cpu_rdata = '0;
        endcase
    end

    a_r9_ctrl_ready_low: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_CTRL) |-> (!rdy_a && !rdy_b));
    a_r1_input_undriven: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_IN) |-> (pin_oe == '0));
    a_r8_rdy_b_bidir_only: assert property (@(posedge clk) disable iff (!rst_n)
        rdy_b |-> is_bidir);
endmodule

// File: tb/pport_ctrl_test.sv
// Scoreboard bench: drivers queue each expected interrupt, and a monitor
// pops one entry for every irq pulse it sees.
module pport_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cpu_wr = 1'b0, cpu_rd = 1'b0;
    logic [1:0] cpu_sel = 2'd0;
    logic [7:0] cpu_wdata = 8'h00;
    logic [7:0] cpu_rdata, pin_in = 8'h00, pin_out, pin_oe;
    logic       stb_a_n = 1'b1, stb_b_n = 1'b1;
    logic       rdy_a, rdy_b, irq;

    int    n_chk = 0, n_err = 0;
    string exp_q[$];
    logic  irq_prev = 1'b0;
    logic  [7:0] rv;

    always #10 clk = ~clk;

    pport_ctrl uut (
        .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
        .cpu_sel(cpu_sel), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
        .stb_a_n(stb_a_n), .stb_b_n(stb_b_n),
        .rdy_a(rdy_a), .rdy_b(rdy_b), .irq(irq));

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cpu_write(input logic [1:0] sel, input logic [7:0] d);
        @(negedge clk); cpu_wr = 1'b1; cpu_sel = sel; cpu_wdata = d;
        @(negedge clk); cpu_wr = 1'b0;
    endtask

    task automatic cpu_read(input logic [1:0] sel, output logic [7:0] d);
        @(negedge clk); cpu_rd = 1'b1; cpu_sel = sel;
        #1 d = cpu_rdata;
        @(negedge clk); cpu_rd = 1'b0;
    endtask

    task automatic pulse_a(input string tag);
        if (tag != "") exp_q.push_back(tag);
        @(negedge clk); stb_a_n = 1'b0;
        repeat (4) @(negedge clk);
        stb_a_n = 1'b1;
        repeat (5) @(negedge clk);
    endtask

    task automatic pulse_b(input string tag);
        if (tag != "") exp_q.push_back(tag);
        @(negedge clk); stb_b_n = 1'b0;
        repeat (4) @(negedge clk);
        stb_b_n = 1'b1;
        repeat (5) @(negedge clk);
    endtask

    // Monitor: each irq pulse must match a queued handshake and last one cycle.
    always @(negedge clk) begin
        if (rst_n && irq) begin
            n_chk++;
            if (exp_q.size() == 0) begin
                n_err++;
                $display("FAIL R6/R9: actual=unexpected irq expected=no irq");
            end else begin
                void'(exp_q.pop_front());
            end
            if (irq_prev) begin
                n_err++;
                $display("FAIL R3: actual=irq 2 cycles expected=1 cycle");
            end
        end
        irq_prev = irq;
    end

    initial begin
        #2_000_000;
        n_err++; n_chk++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 rdy_a", {7'b0, rdy_a}, 8'h01);
        check("R1 rdy_b", {7'b0, rdy_b}, 8'h00);
        check("R1 oe", pin_oe, 8'h00);
        check("R1 irq", {7'b0, irq}, 8'h00);
        cpu_read(2'd1, rv); check("R10 mode input", rv, 8'h01);

        // R4/R5: input handshake
        pin_in = 8'hA5;
        pulse_a("R4");
        check("R4 rdy_a after capture", {7'b0, rdy_a}, 8'h00);
        cpu_read(2'd0, rv); check("R5 read data", rv, 8'hA5);
        check("R5 rdy_a after read", {7'b0, rdy_a}, 8'h01);

        // R6: no overwrite while full
        pin_in = 8'h3C;
        pulse_a("R4");
        pin_in = 8'hFF;
        pulse_a("");
        check("R6 rdy_a held low", {7'b0, rdy_a}, 8'h00);
        cpu_read(2'd0, rv); check("R6 data kept", rv, 8'h3C);

        // R2/R3: output handshake
        cpu_write(2'd1, 8'h00);
        check("R3 rdy_a idle", {7'b0, rdy_a}, 8'h00);
        cpu_write(2'd0, 8'h96);
        check("R2 rdy_a", {7'b0, rdy_a}, 8'h01);
        check("R2 pin_out", pin_out, 8'h96);
        check("R2 oe", pin_oe, 8'hFF);
        pulse_a("R3");
        check("R3 rdy_a dropped", {7'b0, rdy_a}, 8'h00);
        repeat (6) @(negedge clk);
        check("R3 rdy_a stays low", {7'b0, rdy_a}, 8'h00);

        // R7: bidirectional outbound
        cpu_write(2'd1, 8'h02);
        cpu_write(2'd0, 8'h5A);
        check("R7 rdy_a", {7'b0, rdy_a}, 8'h01);
        check("R7 oe idle", pin_oe, 8'h00);
        exp_q.push_back("R7");
        @(negedge clk); stb_a_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R7 oe during strobe", pin_oe, 8'hFF);
        check("R7 pin_out", pin_out, 8'h5A);
        stb_a_n = 1'b1;
        repeat (5) @(negedge clk);
        check("R7 oe released", pin_oe, 8'h00);
        check("R7 rdy_a after ack", {7'b0, rdy_a}, 8'h00);

        // R8: bidirectional inbound
        check("R8 rdy_b empty", {7'b0, rdy_b}, 8'h01);
        pin_in = 8'h71;
        pulse_b("R8");
        check("R8 rdy_b full", {7'b0, rdy_b}, 8'h00);
        cpu_read(2'd0, rv); check("R8 data", rv, 8'h71);
        check("R5 rdy_b after read", {7'b0, rdy_b}, 8'h01);

        // R9: bit-control
        cpu_write(2'd1, 8'h03);
        cpu_write(2'd2, 8'h0F);
        check("R9 oe mask", pin_oe, 8'h0F);
        check("R9 rdy_a", {7'b0, rdy_a}, 8'h00);
        check("R9 rdy_b", {7'b0, rdy_b}, 8'h00);
        pin_in = 8'hC3;
        cpu_read(2'd0, rv); check("R9 direct read", rv, 8'hC3);
        pulse_a("");
        pulse_b("");
        check("R9 strobes ignored rdy_a", {7'b0, rdy_a}, 8'h00);
        cpu_read(2'd1, rv); check("R10 mode ctrl", rv, 8'h03);
        cpu_read(2'd2, rv); check("R9 mask readback", rv, 8'h0F);

        repeat (4) @(negedge clk);
        check("R3/R4 all irqs seen", 8'(exp_q.size()), 8'h00);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule